// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Selectable Pin Routing

This block pairs a serial transmitter with a serial receiver that share one baud tick generator. A 13-bit divisor sets the oversampling tick rate, and every bit on the line lasts sixteen ticks. Characters carry eight or nine data bits. The least significant bit goes first. Each character is framed by a low start bit and a high stop bit, and the line rests high between characters.

Two configuration bits choose how the transmitter and receiver reach the outside. In separate-pin mode the receiver listens to its own input pin. In internal loopback mode the receiver hears the transmitter directly, and the receive pin is disregarded. In single-wire mode both share the transmit pin, which is driven only while a character is going out.

The host offers a character with a valid/ready handshake. It collects each received character from a one-cycle strobe that also carries a framing-error flag.

Top module: `uart_loop_top`

## Requirements
- R1: With divisor BR from 1 to 8191, each bit on the transmit line lasts 16×BR clock cycles, and a full 8-bit character (10 bits) occupies 160×BR cycles from acceptance to ready. Writing a new divisor restarts the tick count.
- R2: With BR = 0 no ticks are produced. A character in progress freezes, `tx_ready` stays low, and the receiver never strobes.
- R3: With `len9` = 0 the transmitted frame is one low start bit, then data bits 0 to 7 in that order, then one high stop bit. The line is high whenever the transmitter is idle.
- R4: With `len9` = 1, data bit 8 follows data bit 7 and precedes the stop bit, in both directions. In 8-bit mode `rx_data[8]` reads 0.
- R5: With `loop_en` = 0 the receiver takes `rxd_in`, and `txd_oe` is held at 1. `loop_src_pin` has no effect in this mode.
- R6: With `loop_en` = 1 and `loop_src_pin` = 0, the receiver hears the transmitter internally, and `rxd_in` has no effect.
- R7: With `loop_en` = 1 and `loop_src_pin` = 1, `txd_oe` is high only while a character is being sent. The receiver listens to `txd_in`, so it hears both its own transmitter and an external driver on the shared wire.
- R8: A character whose stop bit is sampled low is delivered with `rx_frame_err` = 1. A correctly stopped character is delivered with 0.
- R9: A character is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low for the whole frame.
- R10: Each received character raises `rx_valid` for exactly one cycle, with the matching `rx_data` and `rx_frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | 13 | Baud divisor BR; 0 stops the tick generator |
| loop_en | input | 1 | 1 routes the receiver away from `rxd_in` |
| loop_src_pin | input | 1 | With `loop_en`: 0 internal loop, 1 single-wire on the transmit pin |
| len9 | input | 1 | 1 selects 9 data bits per character |
| tx_data | input | 9 | Character to send (bit 8 used only when `len9` = 1) |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| rx_data | output | 9 | Received character |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_frame_err | output | 1 | Stop bit of the strobed character was low |
| txd_out | output | 1 | Transmit pin data |
| txd_oe | output | 1 | Transmit pin output enable |
| txd_in | input | 1 | Level observed on the transmit pin |
| rxd_in | input | 1 | Receive pin |

## Verification
In separate-pin mode the transmitter and the receiver run independently. A transmit handshake or a transmit bit boundary can therefore land in the same clock as a receive strobe. The bench provokes this by launching a transmit character and a receive-pin character together, from forked processes, so that both frames overlap.

Two checks judge the overlap. A bench decoder, timed only by the divisor, recovers the transmit character. A queue of expected received characters is compared on every clock in which the strobe is high. On each clock the bench also confirms the ready and output-enable rules of the current routing mode.

// File: rtl/uart_loop_pkg.sv
package uart_loop_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  typedef enum logic [1:0] {
    ROUTE_PINS     = 2'd0,
    ROUTE_INTERNAL = 2'd1,
    ROUTE_WIRE     = 2'd2
  } route_e;

  function automatic route_e decode_route(input logic loop_en, input logic src_pin);
    if (!loop_en)    return ROUTE_PINS;
    else if (src_pin) return ROUTE_WIRE;
    else             return ROUTE_INTERNAL;
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    div_q <= div;
    if (rst || (div != div_q)) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == div - DIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int OVS    = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              len9,
  input  logic [DATA_W-1:0] data,
  input  logic              valid,
  output logic              ready,
  output logic              line,
  output logic              busy
);
  localparam int SUB_W   = $clog2(OVS);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh;
  logic [SUB_W-1:0]   sub;
  logic [CNT_W-1:0]   left;
  logic               busy_q;

  assign ready = ~busy_q;
  assign busy  = busy_q;
  assign line  = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '1;
      sub    <= '0;
      left   <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (valid) begin
        if (len9) begin
          sh   <= {1'b1, data, 1'b0};
          left <= CNT_W'(FRAME_W);
        end else begin
          sh   <= {2'b11, data[DATA_W-2:0], 1'b0};
          left <= CNT_W'(FRAME_W - 1);
        end
        sub    <= '0;
        busy_q <= 1'b1;
      end
    end else if (tick) begin
      if (sub == SUB_W'(OVS - 1)) begin
        sub  <= '0;
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        left <= left - CNT_W'(1);
        if (left == CNT_W'(1)) busy_q <= 1'b0;
      end else begin
        sub <= sub + SUB_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_loop_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              len9,
  input  logic              serial,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              ferr
);
  localparam int SUB_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam int HALF  = OVS / 2;

  logic              s1, s2;
  rx_state_e         st;
  logic [SUB_W-1:0]  sub;
  logic [BIT_W-1:0]  bits;
  logic [DATA_W-1:0] shreg;
  logic              len_q;
  logic [BIT_W-1:0]  last_bit;

  assign last_bit = len_q ? BIT_W'(DATA_W - 1) : BIT_W'(DATA_W - 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= serial;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RX_IDLE;
      sub   <= '0;
      bits  <= '0;
      shreg <= '0;
      len_q <= 1'b0;
      data  <= '0;
      valid <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (tick && !s2) begin
            st    <= RX_START;
            sub   <= '0;
            len_q <= len9;
          end
        end
        RX_START: begin
          if (tick) begin
            if (sub == SUB_W'(HALF - 1)) begin
              sub  <= '0;
              bits <= '0;
              st   <= s2 ? RX_IDLE : RX_DATA;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (sub == SUB_W'(OVS - 1)) begin
              sub   <= '0;
              shreg <= {s2, shreg[DATA_W-1:1]};
              bits  <= bits + BIT_W'(1);
              if (bits == last_bit) st <= RX_STOP;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (sub == SUB_W'(OVS - 1)) begin
              sub   <= '0;
              valid <= 1'b1;
              ferr  <= ~s2;
              data  <= len_q ? shreg : {1'b0, shreg[DATA_W-1:1]};
              st    <= RX_IDLE;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_loop_top.sv
module uart_loop_top
  import uart_loop_pkg::*;
#(
  parameter int DIV_W  = 13,
  parameter int OVS    = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              loop_en,
  input  logic              loop_src_pin,
  input  logic              len9,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_frame_err,
  output logic              txd_out,
  output logic              txd_oe,
  input  logic              txd_in,
  input  logic              rxd_in
);
  logic   tick;
  logic   tx_line;
  logic   tx_busy;
  logic   rx_serial;
  route_e route;

  assign route = decode_route(loop_en, loop_src_pin);

  uart_baud_gen #(.DIV_W(DIV_W)) baud_i (
    .clk  (clk),
    .rst  (rst),
    .div  (baud_div),
    .tick (tick)
  );

  uart_tx_core #(.OVS(OVS), .DATA_W(DATA_W)) tx_i (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .len9  (len9),
    .data  (tx_data),
    .valid (tx_valid),
    .ready (tx_ready),
    .line  (tx_line),
    .busy  (tx_busy)
  );

  always_comb begin
    case (route)
      ROUTE_INTERNAL: rx_serial = tx_line;
      ROUTE_WIRE:     rx_serial = txd_in;
      default:        rx_serial = rxd_in;
    endcase
  end

  assign txd_out = tx_line;
  assign txd_oe  = (route == ROUTE_WIRE) ? tx_busy : 1'b1;

  uart_rx_core #(.OVS(OVS), .DATA_W(DATA_W)) rx_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .len9   (len9),
    .serial (rx_serial),
    .data   (rx_data),
    .valid  (rx_valid),
    .ferr   (rx_frame_err)
  );
endmodule

// File: rtl/uart_loop_chk.sv
module uart_loop_chk #(
  parameter int DIV_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] baud_div,
  input logic             loop_en,
  input logic             loop_src_pin,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             txd_out,
  input logic             txd_oe
);
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R7
  wire_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (loop_en && loop_src_pin && txd_oe) |-> !tx_ready);

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> txd_out);

  // R10
  strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R2
  halt_tx_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(baud_div, 1) == '0 && $past(baud_div, 2) == '0 && !$past(tx_valid && tx_ready))
      |-> $stable(txd_out));

  // R2
  halt_rx_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(baud_div, 1) == '0 && $past(baud_div, 2) == '0) |-> !rx_valid);
endmodule

bind uart_loop_top uart_loop_chk #(.DIV_W(DIV_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .baud_div     (baud_div),
  .loop_en      (loop_en),
  .loop_src_pin (loop_src_pin),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .rx_valid     (rx_valid),
  .txd_out      (txd_out),
  .txd_oe       (txd_oe)
);

// File: tb/uart_loop_top_tb_top.sv
module uart_loop_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] baud_div = 13'd1;
  logic        loop_en = 1'b0, loop_src_pin = 1'b0, len9 = 1'b0;
  logic [8:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, rx_valid, rx_frame_err, txd_out, txd_oe;
  logic [8:0]  rx_data;
  logic        rxd_drv = 1'b1, wire_drv = 1'b1;
  wire         wire_line = txd_oe ? txd_out : wire_drv;

  int vec = 0, bad = 0, cur_br = 1;
  bit dec_on = 1'b0, dec_busy = 1'b0;
  int    exp_tx[$];
  int    exp_rx[$];
  string exp_tag[$];

  always #5 clk = ~clk;

  uart_loop_top dut_i (
    .clk(clk), .rst(rst), .baud_div(baud_div), .loop_en(loop_en),
    .loop_src_pin(loop_src_pin), .len9(len9), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_frame_err(rx_frame_err), .txd_out(txd_out),
    .txd_oe(txd_oe), .txd_in(wire_line), .rxd_in(rxd_drv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the mode rules and expected receive queue
  always @(negedge clk) begin
    if (!rst) begin
      if (dec_busy) chk(!tx_ready, "R9 ready low in frame", tx_ready, 0);
      if (!loop_en) chk(txd_oe, "R5 oe held high", txd_oe, 1);
      if (loop_en && loop_src_pin && !txd_oe)
        chk(tx_ready, "R7 oe low only when idle", tx_ready, 1);
      if (rx_valid) begin
        if (exp_rx.size() == 0) chk(1'b0, "R10 unexpected strobe", rx_data, 0);
        else begin
          int    e;
          string t;
          e = exp_rx.pop_front();
          t = exp_tag.pop_front();
          chk({rx_frame_err, rx_data} == e[9:0], t, {rx_frame_err, rx_data}, e);
        end
      end
    end
  end

  // behavioural line decoder for the transmit pin
  initial begin
    forever begin
      @(negedge clk);
      if (dec_on && !rst && wire_line === 1'b0) begin
        int nb, v;
        dec_busy = 1'b1;
        nb = len9 ? 9 : 8;
        v = 0;
        repeat (8 * cur_br) @(negedge clk);
        chk(wire_line == 1'b0, "R3 start bit low", wire_line, 0);
        for (int i = 0; i < nb; i++) begin
          repeat (16 * cur_br) @(negedge clk);
          v[i] = wire_line;
        end
        repeat (16 * cur_br) @(negedge clk);
        chk(wire_line == 1'b1, "R3 stop bit high", wire_line, 1);
        if (exp_tx.size() == 0) chk(1'b0, "R3 unexpected frame", v, 0);
        else begin
          int e;
          e = exp_tx.pop_front();
          chk(v == e, nb == 9 ? "R4 nine-bit tx char" : "R3 tx char", v, e);
        end
        dec_busy = 1'b0;
      end
    end
  end

  task automatic send_tx(input int v);
    @(negedge clk);
    tx_data  = v[8:0];
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic put_bit(input bit on_wire, input bit b, input int cyc);
    if (on_wire) wire_drv = b; else rxd_drv = b;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic drive_rx(input int v, input int nb, input bit stop_ok, input bit on_wire);
    @(negedge clk);
    put_bit(on_wire, 1'b0, 16 * cur_br);
    for (int i = 0; i < nb; i++) put_bit(on_wire, v[i], 16 * cur_br);
    if (stop_ok) put_bit(on_wire, 1'b1, 16 * cur_br);
    else begin
      put_bit(on_wire, 1'b0, 12 * cur_br);
      put_bit(on_wire, 1'b1, 32 * cur_br);
    end
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_rx.size() != 0 || exp_tx.size() != 0 || dec_busy || !tx_ready) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (20 * cur_br) @(negedge clk);
  endtask

  task automatic expect_rx(input int v, input string tag);
    exp_rx.push_back(v);
    exp_tag.push_back(tag);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd_out == 1'b1, "R3 reset line high", txd_out, 1);
    chk(tx_ready == 1'b1, "R9 reset ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R10 reset no strobe", rx_valid, 0);
    chk(txd_oe == 1'b1, "R5 reset oe", txd_oe, 1);
    dec_on = 1'b1;

    // separate pins, transmit and receive overlapping
    exp_tx.push_back(32'h0A5);
    expect_rx(32'h03C, "R5 rx from pin");
    fork
      send_tx(32'h0A5);
      drive_rx(32'h03C, 8, 1'b1, 1'b0);
    join
    drain();

    // loop_src_pin ignored without loop_en
    loop_src_pin = 1'b1;
    exp_tx.push_back(32'h05E);
    expect_rx(32'h0C1, "R5 source bit ignored");
    fork
      send_tx(32'h05E);
      drive_rx(32'h0C1, 8, 1'b1, 1'b0);
    join
    drain();
    loop_src_pin = 1'b0;

    // slower divisor and frame length
    baud_div = 13'd3;
    cur_br = 3;
    repeat (10) @(negedge clk);
    exp_tx.push_back(32'h096);
    send_tx(32'h096);
    begin
      int n = 0;
      while (!tx_ready && n < 2000) begin
        @(negedge clk);
        n++;
      end
      chk(n >= 477 && n <= 484, "R1 frame duration", n, 480);
    end
    expect_rx(32'h069, "R1 rx at divisor 3");
    drive_rx(32'h069, 8, 1'b1, 1'b0);
    drain();
    baud_div = 13'd1;
    cur_br = 1;
    repeat (10) @(negedge clk);

    // internal loopback, nine bits, receive pin held low
    loop_en = 1'b1;
    len9 = 1'b1;
    rxd_drv = 1'b0;
    exp_tx.push_back(32'h1C3);
    expect_rx(32'h1C3, "R6 loopback nine-bit char");
    send_tx(32'h1C3);
    drain();
    exp_tx.push_back(32'h100);
    expect_rx(32'h100, "R4 ninth bit alone");
    send_tx(32'h100);
    drain();
    rxd_drv = 1'b1;
    len9 = 1'b0;

    // single wire
    loop_src_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd_oe == 1'b0, "R7 oe low idle", txd_oe, 0);
    exp_tx.push_back(32'h05A);
    expect_rx(32'h05A, "R7 own char on wire");
    send_tx(32'h05A);
    chk(txd_oe == 1'b1, "R7 oe high in frame", txd_oe, 1);
    drain();
    chk(txd_oe == 1'b0, "R7 oe released", txd_oe, 0);
    dec_on = 1'b0;
    expect_rx(32'h0C3, "R7 external char on wire");
    drive_rx(32'h0C3, 8, 1'b1, 1'b1);
    drain();
    dec_on = 1'b1;
    loop_en = 1'b0;
    loop_src_pin = 1'b0;
    repeat (4) @(negedge clk);

    // framing error, then a clean character
    expect_rx(32'h255, "R8 framing error flagged");
    drive_rx(32'h055, 8, 1'b0, 1'b0);
    drain();
    expect_rx(32'h0AA, "R8 clean stop no error");
    drive_rx(32'h0AA, 8, 1'b1, 1'b0);
    drain();

    // divisor zero halts everything
    dec_on = 1'b0;
    baud_div = 13'd0;
    repeat (4) @(negedge clk);
    rxd_drv = 1'b0;
    send_tx(32'h033);
    repeat (300) @(negedge clk);
    chk(tx_ready == 1'b0, "R2 frame frozen ready", tx_ready, 0);
    chk(txd_out == 1'b0, "R2 frame frozen line", txd_out, 0);
    rxd_drv = 1'b1;
    repeat (4) @(negedge clk);
    baud_div = 13'd1;
    begin
      int t = 0;
      while (!tx_ready && t < 2000) begin
        @(negedge clk);
        t++;
      end
      chk(tx_ready == 1'b1, "R2 resumes after divisor set", tx_ready, 1);
    end
    repeat (40) @(negedge clk);
    chk(exp_rx.size() == 0 && exp_tx.size() == 0, "R10 all chars seen",
        exp_rx.size() + exp_tx.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule